// File: doc/BRIEF.md
# Hot-swap insertion power sequencer

This controller decides when a plug-in card may close its backend power switches. It watches two card-presence contacts, one at each end of the connector. Both contacts must be low, and each must pass a long glitch filter clocked by a slow timer tick. Once presence is confirmed, it checks a host power permit. It then checks host supply-good flags, and a supply-select input chooses which of those flags are monitored. When every condition holds, it turns on the enables for the 3.3 V and 5 V switch paths together.

The enables are cleared by reset and stay off until the whole sequence is complete. If a monitored host supply fails while power is on, the enables are withdrawn on the next clock edge and the controller waits for the supply to return. If either presence contact is lost, or the permit is withdrawn, the controller returns to idle. Losing presence also means a full filter period must pass again before power can return. All inputs are digital flags that are already synchronous to the clock. The tick is a one-cycle pulse from a clock-enable timer, nominally one per millisecond. The default filter length is 150 ticks.

Top module: `hs_pwr_seq`

## Requirements
- R1: While reset is high and directly after it, both gate enables are 0 and the sequencer state is 2'b00 (idle).
- R2: A presence contact qualifies only after FILT_LEN consecutive ticks with its level low. After FILT_LEN-1 such ticks the state is still 2'b00.
- R3: A high level on a presence contact clears its count at once, so a glitch restarts the full filter period.
- R4: Both presence contacts must be qualified. With only one low, the state stays 2'b00 however many ticks arrive.
- R5: With presence confirmed and the permit low, the state holds at 2'b01 (waiting for permit) and the gates stay off.
- R6: Supply select: 2'b00 and 2'b11 monitor both host flags, 2'b01 monitors only the 3.3 V flag, and 2'b10 monitors only the 5 V flag. A flag that is not monitored has no effect on the gates.
- R7: When presence, permit and the monitored supplies all hold, the state passes through 2'b10 (supply check) to 2'b11 (on), and both gate enables go to 1 together.
- R8: If a monitored supply flag falls while the state is 2'b11, both gates are 0 and the state is 2'b10 after the next clock edge. They return to 1 one edge after the flag recovers.
- R9: Loss of either presence contact, or a low permit in state 2'b10 or 2'b11, gives state 2'b00 with the gates off after the next edge. After a presence loss, a new full filter period is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle timer tick that advances the presence filters |
| present_n | input | 2 | Presence contacts, low means inserted |
| host_permit | input | 1 | Host power permit, high allows power-up |
| supply_sel | input | 2 | Selects which host supply flags are monitored |
| host_3v3_ok | input | 1 | Host 3.3 V supply above threshold |
| host_5v_ok | input | 1 | Host 5 V supply above threshold |
| gate_en_3v3 | output | 1 | Enable for the 3.3 V switch path |
| gate_en_5v | output | 1 | Enable for the 5 V switch path |
| seq_state | output | 2 | Sequencer state: 00 idle, 01 permit wait, 10 supply check, 11 on |

## Verification
The assertions assume that every input is already synchronous to the clock, and that tick_ms is high for only one cycle at a time. They also assume that filter progress is counted only at clock edges where tick_ms is high. The stimulus changes every input on the falling clock edge. Ticks are produced as a single high cycle followed by a low cycle, so the number of ticks the filters see is exactly the number the bench counts. Supply and permit changes are held for at least one rising edge, which keeps each withdrawal and recovery inside the one-edge windows the properties describe.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_PERMIT = 2'b01,
    ST_CHECK  = 2'b10,
    ST_ON     = 2'b11
  } seq_state_e;

  localparam logic [1:0] SEL_3V3_ONLY = 2'b01;
  localparam logic [1:0] SEL_5V_ONLY  = 2'b10;
endpackage

// File: rtl/hs_presence_filter.sv
module hs_presence_filter #(
  parameter int FILT_LEN = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin_n,
  output logic qualified
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (pin_n)             cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign qualified = (cnt == LIM) && !pin_n;

  // R2
  cnt_limit_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LIM);
  // R3
  high_clears_chk: assert property (@(posedge clk) disable iff (rst) pin_n |=> cnt == '0);
  // R2
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cnt) || cnt == '0));
endmodule

// File: rtl/hs_supply_chk.sv
module hs_supply_chk
  import hs_seq_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       ok_3v3,
  input  logic       ok_5v,
  output logic       supply_ok
);
  always_comb begin
    case (sel)
      SEL_3V3_ONLY: supply_ok = ok_3v3;
      SEL_5V_ONLY:  supply_ok = ok_5v;
      default:      supply_ok = ok_3v3 && ok_5v;
    endcase
  end
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_seq_pkg::*;
#(
  parameter int N_GATES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               present_ok,
  input  logic               permit,
  input  logic               supply_ok,
  output seq_state_e         state_q,
  output logic [N_GATES-1:0] gate_q
);
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (present_ok) state_d = ST_PERMIT;
      ST_PERMIT: if (!present_ok) state_d = ST_IDLE;
                 else if (permit) state_d = ST_CHECK;
      ST_CHECK:  if (!present_ok || !permit) state_d = ST_IDLE;
                 else if (supply_ok) state_d = ST_ON;
      ST_ON:     if (!present_ok || !permit) state_d = ST_IDLE;
                 else if (!supply_ok) state_d = ST_CHECK;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      gate_q  <= '0;
    end else begin
      state_q <= state_d;
      gate_q  <= {N_GATES{state_d == ST_ON}};
    end
  end

  // R8
  supply_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && !supply_ok && present_ok && permit) |=>
      (gate_q == '0 && state_q == ST_CHECK));
  // R9
  presence_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !present_ok |=> (state_q == ST_IDLE && gate_q == '0));
  // R9
  permit_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_CHECK || state_q == ST_ON) && !permit) |=> state_q == ST_IDLE);
  // R5
  permit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PERMIT && !permit) |=> gate_q == '0);
  // R7
  gate_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q[0]) |-> $past(supply_ok && permit && present_ok));
  // R7
  seq_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON) |-> ($past(state_q) == ST_CHECK || $past(state_q) == ST_ON));
endmodule

// File: rtl/hs_pwr_seq.sv
module hs_pwr_seq
  import hs_seq_pkg::*;
#(
  parameter int FILT_LEN   = 150,
  parameter int N_PRESENCE = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_ms,
  input  logic [N_PRESENCE-1:0] present_n,
  input  logic                  host_permit,
  input  logic [1:0]            supply_sel,
  input  logic                  host_3v3_ok,
  input  logic                  host_5v_ok,
  output logic                  gate_en_3v3,
  output logic                  gate_en_5v,
  output logic [1:0]            seq_state
);
  localparam int N_GATES = 2;

  logic [N_PRESENCE-1:0] qual;
  logic                  supply_ok;
  seq_state_e            state_q;
  logic [N_GATES-1:0]    gate_q;

  for (genvar g = 0; g < N_PRESENCE; g++) begin : g_pin
    hs_presence_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick_ms),
      .pin_n     (present_n[g]),
      .qualified (qual[g])
    );
  end

  hs_supply_chk u_sup (
    .sel       (supply_sel),
    .ok_3v3    (host_3v3_ok),
    .ok_5v     (host_5v_ok),
    .supply_ok (supply_ok)
  );

  hs_seq_fsm #(.N_GATES(N_GATES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .present_ok (&qual),
    .permit     (host_permit),
    .supply_ok  (supply_ok),
    .state_q    (state_q),
    .gate_q     (gate_q)
  );

  assign gate_en_3v3 = gate_q[0];
  assign gate_en_5v  = gate_q[1];
  assign seq_state   = state_q;
endmodule

// File: tb/hs_pwr_seq_tb.sv
`timescale 1ns/1ps
module hs_pwr_seq_tb_top;
  localparam int FL = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic [1:0] present_n = 2'b11;
  logic host_permit = 1'b0;
  logic [1:0] supply_sel = 2'b00;
  logic host_3v3_ok = 1'b0;
  logic host_5v_ok = 1'b0;
  logic gate_en_3v3, gate_en_5v;
  logic [1:0] seq_state;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hs_pwr_seq #(.FILT_LEN(FL), .N_PRESENCE(2)) dut_i (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .present_n(present_n),
    .host_permit(host_permit), .supply_sel(supply_sel),
    .host_3v3_ok(host_3v3_ok), .host_5v_ok(host_5v_ok),
    .gate_en_3v3(gate_en_3v3), .gate_en_5v(gate_en_5v), .seq_state(seq_state)
  );

  // fields: sel[4:3], ok_3v3[2], ok_5v[1], expected gates[0]
  localparam logic [4:0] VEC [0:8] = '{
    5'b00_1_1_1, 5'b00_1_0_0, 5'b00_0_1_0, 5'b01_1_0_1, 5'b01_0_1_0,
    5'b10_0_1_1, 5'b10_1_0_0, 5'b11_1_0_0, 5'b11_1_1_1
  };

  task automatic check_out(string req, logic [1:0] st, logic g);
    checks++;
    if ({seq_state, gate_en_3v3, gate_en_5v} !== {st, g, g}) begin
      errors++;
      $display("FAIL %s: state=%b gates=%b%b expected state=%b gates=%b%b",
               req, seq_state, gate_en_3v3, gate_en_5v, st, g, g);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    check_out("R1 in reset", 2'b00, 1'b0);
    rst = 1'b0;
    present_n = 2'b00; host_permit = 1'b1; host_3v3_ok = 1'b1; host_5v_ok = 1'b1;
    wait_n(2);
    check_out("R1 after reset", 2'b00, 1'b0);

    ticks(FL - 1);
    wait_n(3);
    check_out("R2 one tick short", 2'b00, 1'b0);
    ticks(1);
    wait_n(3);
    check_out("R7 powered on", 2'b11, 1'b1);

    for (int i = 0; i < 9; i++) begin
      supply_sel = VEC[i][4:3];
      host_3v3_ok = VEC[i][2];
      host_5v_ok = VEC[i][1];
      wait_n(2);
      check_out($sformatf("R6 vector %0d", i), VEC[i][0] ? 2'b11 : 2'b10, VEC[i][0]);
    end

    supply_sel = 2'b00;
    host_5v_ok = 1'b0;
    wait_n(1);
    check_out("R8 supply loss one edge", 2'b10, 1'b0);
    host_5v_ok = 1'b1;
    wait_n(1);
    check_out("R8 supply recovery", 2'b11, 1'b1);

    host_permit = 1'b0;
    wait_n(1);
    check_out("R9 permit drop", 2'b00, 1'b0);
    wait_n(3);
    check_out("R5 permit wait", 2'b01, 1'b0);
    host_permit = 1'b1;
    wait_n(3);
    check_out("R5 permit restored", 2'b11, 1'b1);

    present_n[0] = 1'b1;
    wait_n(1);
    check_out("R9 presence loss", 2'b00, 1'b0);
    present_n[0] = 1'b0;
    wait_n(3);
    check_out("R9 refilter needed", 2'b00, 1'b0);

    ticks(FL - 1);
    present_n[0] = 1'b1;
    wait_n(1);
    present_n[0] = 1'b0;
    ticks(FL - 1);
    wait_n(3);
    check_out("R3 glitch restarts", 2'b00, 1'b0);
    ticks(1);
    wait_n(3);
    check_out("R3 full period after glitch", 2'b11, 1'b1);

    present_n[1] = 1'b1;
    ticks(FL + 2);
    wait_n(2);
    check_out("R4 single contact", 2'b00, 1'b0);
    present_n[1] = 1'b0;
    ticks(FL);
    wait_n(3);
    check_out("R4 both contacts", 2'b11, 1'b1);

    rst = 1'b1;
    wait_n(1);
    check_out("R1 reset from on", 2'b00, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule